// File: doc/BRIEF.md
# Serial Line Transmitter with Framing Control

This block turns bytes written by a host into an asynchronous serial bit stream. Bytes go into a small transmit queue. When the transmitter is enabled, a framer takes the oldest byte and sends it on the `txd` line. Each character has a low start bit, then seven or eight data bits with the least significant bit first, then an optional parity bit, then one or two high stop bits. A line-control register sets the framing. A ten-bit divisor sets the bit rate. A break control holds the line low for as long as it stays set.

The host uses a single write port. Each write selects one of four targets: the queue, the divisor, the line-control register, or a queue-control register used to flush the queue. The block reports three things at its outputs: how full the queue is, a sticky flag that is set when a byte is lost to a full queue, and a busy flag. The busy flag is high while a character is on the wire. While busy is high, divisor writes are refused, so the bit period never changes partway through a character.

Top module: `uart_tx_line`

## Requirements
- R1: After reset, `txd` is 1, `busy` is 0, `fifo_level` is 0 and `fifo_ovf` is 0. The divisor resets to 7 and every line-control bit resets to 0.
- R2: `wr_addr` selects the write target: 0 is the queue, 1 the divisor, 2 line control, 3 queue control. The queue holds 16 bytes, and `fifo_level` shows the current count. A data write to a full queue is dropped and sets `fifo_ovf`, which stays set.
- R3: A queue-control write with `wr_data[0]`=1 empties the queue and clears `fifo_ovf` at the following clock edge. The flush request then clears itself.
- R4: Line-control bit 0 enables the transmitter. While it is 0, no character starts and written bytes wait in the queue.
- R5: `txd` idles high. A character begins with one low start bit, followed by the data bits LSB first. Line-control bit 2 selects the width: 1 means 8 data bits, 0 means 7 (bit 7 of the byte is not sent).
- R6: Line-control bit 4 adds a parity bit after the data bits. Line-control bit 5 selects the sense: 1 makes the number of ones in data plus parity odd, 0 makes it even.
- R7: Line-control bit 3 selects two stop bits when 1 and one stop bit when 0.
- R8: Every bit lasts 16*(D+1) clock cycles, where D is the divisor taken from `wr_data[9:0]`.
- R9: `busy` is high from the clock after a character starts until its last stop bit ends. A divisor write while `busy` is high is ignored.
- R10: Line-control bit 9 forces `txd` low while it is set. The line returns to its normal level once the bit is cleared.
- R11: When more bytes are waiting, the next character starts one clock cycle after the previous one ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | Write target select |
| wr_data | input | 16 | Write data |
| fifo_level | output | 5 | Number of bytes in the queue |
| fifo_ovf | output | 1 | Sticky flag: a byte was lost to a full queue |
| busy | output | 1 | A character is in flight |
| txd | output | 1 | Serial output line |

## Verification
The hardest case to reach is a divisor write that arrives while a character is in flight. Its effect shows up only on the next character, and only as a change in bit length. To reach it, the stimulus queues two all-ones bytes at a slow rate and writes a fast divisor once busy rises. It then times the start bit of the second character, which must still be at the slow rate. A behavioural model steps alongside the design on every clock, so the one-clock gap between back-to-back characters is also compared. The same applies to the points where a flush overlaps a pending write.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  typedef enum logic [1:0] {
    SEL_QUEUE = 2'd0,
    SEL_DIV   = 2'd1,
    SEL_LINE  = 2'd2,
    SEL_QCTL  = 2'd3
  } wr_sel_e;

  localparam int LB_TXEN   = 0;
  localparam int LB_WIDE   = 2;
  localparam int LB_STOP2  = 3;
  localparam int LB_PAREN  = 4;
  localparam int LB_PARODD = 5;
  localparam int LB_BREAK  = 9;

  typedef struct packed {
    logic brk;
    logic par_odd;
    logic par_en;
    logic stop2;
    logic wide;
    logic tx_en;
  } line_cfg_t;

endpackage

// File: rtl/uart_tx_fifo.sv
module uart_tx_fifo #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush_i,
  input  logic             push_i,
  input  logic [WIDTH-1:0] din_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] dout_o,
  output logic [LVL_W-1:0] level_o,
  output logic             empty_o,
  output logic             ovf_o
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] rd_q, rd_n, wr_q, wr_n;
  logic [LVL_W-1:0] lvl_q, lvl_n;
  logic             ovf_q, ovf_n;
  logic             full, push_ok, pop_ok;

  assign full    = (lvl_q == LVL_W'(DEPTH));
  assign empty_o = (lvl_q == '0);
  assign push_ok = push_i & ~full & ~flush_i;
  assign pop_ok  = pop_i & ~empty_o & ~flush_i;

  always_comb begin
    rd_n  = rd_q;
    wr_n  = wr_q;
    lvl_n = lvl_q;
    ovf_n = ovf_q;
    if (flush_i) begin
      rd_n  = '0;
      wr_n  = '0;
      lvl_n = '0;
      ovf_n = 1'b0;
    end else begin
      if (push_i && full) ovf_n = 1'b1;
      if (push_ok) wr_n = (wr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      if (pop_ok)  rd_n = (rd_q == PTR_W'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      lvl_n = lvl_q + LVL_W'(push_ok) - LVL_W'(pop_ok);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      lvl_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      rd_q  <= rd_n;
      wr_q  <= wr_n;
      lvl_q <= lvl_n;
      ovf_q <= ovf_n;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_q] <= din_i;
  end

  assign dout_o  = mem[rd_q];
  assign level_o = lvl_q;
  assign ovf_o   = ovf_q;

  // R2
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && full && !flush_i) |=> (ovf_o && level_o == LVL_W'(DEPTH) - LVL_W'($past(pop_ok))));

  // R3
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (level_o == '0 && !ovf_o));

endmodule

// File: rtl/uart_tx_baud.sv
module uart_tx_baud #(
  parameter int DIV_W = 10,
  parameter int OVS   = 16,
  localparam int SMP_W = $clog2(OVS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             bit_end_o
);

  logic [DIV_W-1:0] pre_q, pre_n;
  logic [SMP_W-1:0] smp_q, smp_n;
  logic             tick;

  assign tick      = run_i & (pre_q == div_i);
  assign bit_end_o = tick & (smp_q == SMP_W'(OVS - 1));

  always_comb begin
    pre_n = pre_q;
    smp_n = smp_q;
    if (!run_i) begin
      pre_n = '0;
      smp_n = '0;
    end else if (tick) begin
      pre_n = '0;
      smp_n = (smp_q == SMP_W'(OVS - 1)) ? '0 : smp_q + 1'b1;
    end else begin
      pre_n = pre_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      smp_q <= '0;
    end else begin
      pre_q <= pre_n;
      smp_q <= smp_n;
    end
  end

endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int FRAME_W = DATA_W + 4,
  localparam int CNT_W   = $clog2(FRAME_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [DATA_W-1:0] data_i,
  input  line_cfg_t         cfg_i,
  input  logic              bit_end_i,
  output logic              active_o,
  output logic              line_o
);

  logic [FRAME_W-1:0] frame_d, sh_q, sh_n;
  logic [CNT_W-1:0]   len_d, rem_q, rem_n;
  logic               act_q, act_n;
  logic [DATA_W-1:0]  mask;
  logic               par;
  int                 nb;

  always_comb begin
    nb      = cfg_i.wide ? DATA_W : DATA_W - 1;
    mask    = cfg_i.wide ? '1 : {1'b0, {(DATA_W-1){1'b1}}};
    par     = (^(data_i & mask)) ^ cfg_i.par_odd;
    frame_d = '1;
    frame_d[0] = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < nb) frame_d[1 + i] = data_i[i];
    end
    if (cfg_i.par_en) frame_d[1 + nb] = par;
    len_d = CNT_W'(2 + nb) + CNT_W'(cfg_i.par_en) + CNT_W'(cfg_i.stop2);
  end

  always_comb begin
    act_n = act_q;
    sh_n  = sh_q;
    rem_n = rem_q;
    if (start_i && !act_q) begin
      act_n = 1'b1;
      sh_n  = frame_d;
      rem_n = len_d;
    end else if (act_q && bit_end_i) begin
      sh_n  = {1'b1, sh_q[FRAME_W-1:1]};
      rem_n = rem_q - 1'b1;
      if (rem_q == CNT_W'(1)) act_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      sh_q  <= '1;
      rem_q <= '0;
    end else begin
      act_q <= act_n;
      sh_q  <= sh_n;
      rem_q <= rem_n;
    end
  end

  assign active_o = act_q;
  assign line_o   = act_q ? sh_q[0] : 1'b1;

  // R5
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !active_o) |=> (active_o && !line_o));

endmodule

// File: rtl/uart_tx_line.sv
module uart_tx_line
  import uart_tx_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int DATA_W     = 8,
  parameter int DIV_W      = 10,
  parameter int OVS        = 16,
  parameter int WR_W       = 16,
  parameter int DIV_RESET  = 7,
  localparam int LVL_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [WR_W-1:0]  wr_data,
  output logic [LVL_W-1:0] fifo_level,
  output logic             fifo_ovf,
  output logic             busy,
  output logic             txd
);

  logic [DIV_W-1:0]  div_q, div_n;
  line_cfg_t         cfg_q, cfg_n;
  logic              flush_q, flush_n;
  logic              wr_queue, wr_div, wr_line, wr_qctl;
  logic              fifo_empty, start, bit_end, line;
  logic [DATA_W-1:0] head;

  assign wr_queue = wr_en & (wr_addr == SEL_QUEUE);
  assign wr_div   = wr_en & (wr_addr == SEL_DIV);
  assign wr_line  = wr_en & (wr_addr == SEL_LINE);
  assign wr_qctl  = wr_en & (wr_addr == SEL_QCTL);

  always_comb begin
    div_n   = div_q;
    cfg_n   = cfg_q;
    flush_n = wr_qctl & wr_data[0];
    if (wr_div && !busy) div_n = wr_data[DIV_W-1:0];
    if (wr_line) begin
      cfg_n.tx_en   = wr_data[LB_TXEN];
      cfg_n.wide    = wr_data[LB_WIDE];
      cfg_n.stop2   = wr_data[LB_STOP2];
      cfg_n.par_en  = wr_data[LB_PAREN];
      cfg_n.par_odd = wr_data[LB_PARODD];
      cfg_n.brk     = wr_data[LB_BREAK];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q   <= DIV_W'(DIV_RESET);
      cfg_q   <= '0;
      flush_q <= 1'b0;
    end else begin
      div_q   <= div_n;
      cfg_q   <= cfg_n;
      flush_q <= flush_n;
    end
  end

  assign start = ~busy & cfg_q.tx_en & ~fifo_empty & ~flush_q;

  uart_tx_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(DATA_W)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush_i (flush_q),
    .push_i  (wr_queue),
    .din_i   (wr_data[DATA_W-1:0]),
    .pop_i   (start),
    .dout_o  (head),
    .level_o (fifo_level),
    .empty_o (fifo_empty),
    .ovf_o   (fifo_ovf)
  );

  uart_tx_baud #(.DIV_W(DIV_W), .OVS(OVS)) u_baud (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_i     (busy),
    .div_i     (div_q),
    .bit_end_o (bit_end)
  );

  uart_tx_shift #(.DATA_W(DATA_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start),
    .data_i    (head),
    .cfg_i     (cfg_q),
    .bit_end_i (bit_end),
    .active_o  (busy),
    .line_o    (line)
  );

  assign txd = ~cfg_q.brk & line;

  // R4
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_q.tx_en && !busy) |=> !busy);

  // R9
  div_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_div) |=> $stable(div_q));

endmodule

// File: tb/uart_tx_line_tb.sv
`timescale 1ns/1ps
module uart_tx_line_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [15:0] wr_data = 16'd0;
  logic [4:0]  fifo_level;
  logic        fifo_ovf, busy, txd;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  uart_tx_line u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .fifo_level(fifo_level), .fifo_ovf(fifo_ovf),
    .busy(busy), .txd(txd)
  );

  // behavioural reference
  logic [7:0]  mq[$];
  bit          mf[$];
  int          m_cnt, m_div;
  logic [15:0] m_lcr;
  bit          m_act, m_flush, m_ovf;

  function automatic void build(input logic [7:0] b, input logic [15:0] l);
    int nb, ones;
    nb = l[2] ? 8 : 7;
    ones = 0;
    mf.push_back(1'b0);
    for (int i = 0; i < nb; i++) begin
      mf.push_back(b[i]);
      if (b[i]) ones++;
    end
    if (l[4]) mf.push_back(l[5] ? (ones % 2 == 0) : (ones % 2 == 1));
    mf.push_back(1'b1);
    if (l[3]) mf.push_back(1'b1);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mq.delete(); mf.delete();
      m_cnt = 0; m_div = 7; m_lcr = 16'd0;
      m_act = 0; m_flush = 0; m_ovf = 0;
    end else begin
      bit o_act, o_flush;
      int o_size;
      logic [15:0] o_lcr;
      o_act = m_act; o_flush = m_flush; o_size = mq.size(); o_lcr = m_lcr;
      if (o_act) begin
        m_cnt++;
        if (m_cnt == 16 * (m_div + 1)) begin
          m_cnt = 0;
          void'(mf.pop_front());
          if (mf.size() == 0) m_act = 0;
        end
      end
      if (o_flush) begin
        mq.delete();
        m_ovf = 0;
      end else begin
        if (!o_act && o_lcr[0] && o_size > 0) begin
          build(mq.pop_front(), o_lcr);
          m_act = 1; m_cnt = 0;
        end
        if (wr_en && wr_addr == 2'd0) begin
          if (o_size == 16) m_ovf = 1;
          else mq.push_back(wr_data[7:0]);
        end
      end
      m_flush = wr_en && wr_addr == 2'd3 && wr_data[0];
      if (wr_en && wr_addr == 2'd1 && !o_act) m_div = int'(wr_data[9:0]);
      if (wr_en && wr_addr == 2'd2) m_lcr = wr_data;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit e_txd;
      e_txd = !m_lcr[9] && (m_act ? mf[0] : 1'b1);
      chk(txd == e_txd, "R5 R6 R7 R8 R10 txd", int'(txd), int'(e_txd));
      chk(busy == m_act, "R9 R11 busy", int'(busy), int'(m_act));
      chk(int'(fifo_level) == mq.size(), "R2 level", int'(fifo_level), mq.size());
      chk(fifo_ovf == m_ovf, "R2 R3 ovf", int'(fifo_ovf), int'(m_ovf));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_idle();
    while (busy || fifo_level != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic low_run(output int n);
    n = 0;
    while (txd) @(negedge clk);
    while (!txd) begin n++; @(negedge clk); end
  endtask

  initial begin
    int n;
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(txd == 1'b1, "R1 txd", int'(txd), 1);
    chk(busy == 1'b0, "R1 busy", int'(busy), 0);
    chk(fifo_level == 0, "R1 level", int'(fifo_level), 0);
    chk(fifo_ovf == 1'b0, "R1 ovf", int'(fifo_ovf), 0);

    // R4: transmitter disabled, bytes wait
    for (int i = 0; i < 3; i++) wr(2'd0, 16'(8'h30 + i));
    idle(20);
    chk(busy == 1'b0, "R4 no start", int'(busy), 0);
    chk(fifo_level == 3, "R4 held", int'(fifo_level), 3);

    // R2: fill past 16
    for (int i = 0; i < 14; i++) wr(2'd0, 16'(i));
    chk(fifo_level == 16, "R2 full", int'(fifo_level), 16);
    chk(fifo_ovf == 1'b1, "R2 sticky", int'(fifo_ovf), 1);
    idle(4);
    chk(fifo_ovf == 1'b1, "R2 sticky hold", int'(fifo_ovf), 1);

    // R3: flush
    wr(2'd3, 16'h0001);
    @(negedge clk);
    chk(fifo_level == 0, "R3 flushed", int'(fifo_level), 0);
    chk(fifo_ovf == 1'b0, "R3 ovf clr", int'(fifo_ovf), 0);
    wr(2'd0, 16'h00AA);
    chk(fifo_level == 1, "R3 self clear", int'(fifo_level), 1);
    wr(2'd3, 16'h0001);
    idle(2);

    // R8: div 0, 8N1, start bit length
    wr(2'd1, 16'd0);
    wr(2'd2, 16'h0005);
    wr(2'd0, 16'h00A5);
    low_run(n);
    chk(n == 16, "R8 bit len div0", n, 16);
    wait_idle();

    // R5 R6 R7: 7 bits, even parity, two stop, back-to-back
    wr(2'd2, 16'h0019);
    wr(2'd0, 16'h00C3);
    wr(2'd0, 16'h0081);
    wr(2'd0, 16'h007E);
    wait_idle();
    // odd parity, 8 bits, one stop
    wr(2'd2, 16'h0035);
    wr(2'd0, 16'h0096);
    wr(2'd0, 16'h0001);
    wait_idle();
    // odd parity 7 bits two stop
    wr(2'd2, 16'h0039);
    wr(2'd0, 16'h00F0);
    wait_idle();

    // R9 R11: divisor write refused while busy; one-clock gap
    wr(2'd2, 16'h0005);
    wr(2'd1, 16'd3);
    wr(2'd0, 16'h00FF);
    wr(2'd0, 16'h00FF);
    while (!busy) @(negedge clk);
    wr(2'd1, 16'd0);
    while (busy) @(negedge clk);
    n = 0;
    while (!busy) begin n++; @(negedge clk); end
    chk(n == 1, "R11 gap", n, 1);
    low_run(n);
    chk(n == 64, "R9 div locked", n, 64);
    wait_idle();
    wr(2'd1, 16'd1);
    wr(2'd0, 16'h00FF);
    low_run(n);
    chk(n == 32, "R8 bit len div1", n, 32);
    wait_idle();

    // R10: break
    wr(2'd2, 16'h0205);
    idle(5);
    chk(txd == 1'b0, "R10 break low", int'(txd), 0);
    wr(2'd0, 16'h0055);
    idle(40);
    chk(txd == 1'b0, "R10 break over data", int'(txd), 0);
    wr(2'd2, 16'h0005);
    wait_idle();
    chk(txd == 1'b1, "R10 released", int'(txd), 1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule